// File: doc/BRIEF.md
# Residue-to-Binary Converter (Periodic Jump Method)

This block turns a five-digit residue number over the moduli 11, 7, 5, 3 and 2 into its plain binary value in the range 0 to 2309. It does this by stepping backward through the periodic residue table. Each step subtracts a jump from the current location, and each jump is a multiple of the product of the moduli whose digits are already zero. The multiple is picked so that exactly one more digit becomes zero. The digits of the jump are removed from every remaining channel at once, using small modular subtractors. The binary result is the sum of all jumps taken.

The converter is unrolled into one registered stage per jump. It takes a new tuple every clock cycle and returns each result after a fixed delay, with a valid flag that travels with the data. Input digits are first reduced modulo their own channel, so a 4-bit lane holding a value at or above its modulus is accepted and treated as its remainder.

Top module: `rns_mx_converter`

## Requirements
- R1: Lane i of `in_res` occupies bits [4i+3:4i], and lanes 0 to 4 carry the residues modulo 11, 7, 5, 3 and 2 in that order. For every canonical tuple, `out_value` equals the unique X in 0..2309 whose remainder modulo each lane's modulus equals that lane.
- R2: A lane value at or above its modulus (up to 15) is converted exactly as its remainder modulo that lane's modulus.
- R3: A tuple captured on a rising edge while `in_valid` is 1 produces `out_valid` = 1, with its result, right after the fifth rising edge counted from and including the capture edge. Tuples presented on consecutive cycles give results on consecutive cycles in the same order, and no result appears without a matching input.
- R4: While `out_valid` is 0, `out_value` keeps the last result.
- R5: While `rst_n` is 0, `out_valid` and `out_value` are 0. Tuples presented on the first two rising edges after `rst_n` rises are ignored and produce no result.
- R6: Whenever `out_valid` is 1, `out_value` is below 2310.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Marks a tuple on in_res to be converted |
| in_res | input | 20 | Five 4-bit residue lanes, lane 0 in the low bits |
| out_valid | output | 1 | Marks a result on out_value |
| out_value | output | 12 | Binary value of the converted tuple |

## Verification
On every cycle the assertions check the fixed five-cycle valid latency, the hold of the output while idle, the output bound, and that each result, reduced by every modulus, gives back the digit that entered five cycles earlier. Only the bench's scenarios can show a complete mapping for all 2310 tuples, a correct reduction of out-of-range lane values, the ordering of back-to-back and gapped streams, and that inputs presented during the reset release window are dropped.

// File: rtl/rns_mx_pkg.sv
package rns_mx_pkg;
  localparam int NCH = 5;
  localparam int LW  = 4;
  localparam int unsigned MOD [NCH] = '{11, 7, 5, 3, 2};

  // Product of the moduli of channels 0..k-1
  function automatic int unsigned pre_prod(input int k);
    int unsigned p;
    p = 1;
    for (int i = 0; i < k; i++) p = p * MOD[i];
    return p;
  endfunction

  // Inverse of pre_prod(k) modulo the modulus of channel k
  function automatic int unsigned pre_inv(input int k);
    int unsigned m;
    int unsigned r;
    m = MOD[k];
    r = pre_prod(k) % m;
    for (int unsigned x = 0; x < m; x++)
      if (((r * x) % m) == 1) return x;
    return 0;
  endfunction

  localparam int unsigned RANGE = pre_prod(NCH);
  localparam int VW = $clog2(RANGE);

  typedef logic [LW-1:0]   lane_t;
  typedef lane_t [NCH-1:0] loc_t;
  typedef logic [VW-1:0]   val_t;
endpackage

// File: rtl/rns_mx_rst_sync.sv
module rns_mx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/rns_mx_canon.sv
module rns_mx_canon
  import rns_mx_pkg::*;
(
  input  logic [NCH*LW-1:0] raw,
  output loc_t              loc
);
  // Reduce each 4-bit lane into its own channel range
  always_comb begin
    for (int j = 0; j < NCH; j++)
      loc[j] = LW'(32'(raw[j*LW +: LW]) % MOD[j]);
  end
endmodule

// File: rtl/rns_mx_stage.sv
module rns_mx_stage
  import rns_mx_pkg::*;
#(
  parameter int K = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic v_i,
  input  loc_t loc_i,
  input  val_t acc_i,
  output logic v_o,
  output loc_t loc_o,
  output val_t acc_o
);
  localparam int unsigned MK = MOD[K];
  localparam int unsigned PK = pre_prod(K);
  localparam int unsigned IK = pre_inv(K);

  lane_t       coef;
  val_t        jump;
  val_t        acc_n;
  loc_t        loc_n;
  logic [31:0] sub;

  // Next-state: jump coefficient, jump value and the new location
  always_comb begin
    coef  = LW'((32'(loc_i[K]) * IK) % MK);
    jump  = VW'(32'(coef) * PK);
    acc_n = acc_i + jump;
    sub   = '0;
    for (int j = 0; j < NCH; j++) begin
      if (j <= K) begin
        loc_n[j] = '0;
      end else begin
        sub = (((32'(coef) % MOD[j]) * (PK % MOD[j])) % MOD[j]);
        if (32'(loc_i[j]) >= sub)
          loc_n[j] = LW'(32'(loc_i[j]) - sub);
        else
          loc_n[j] = LW'(32'(loc_i[j]) + MOD[j] - sub);
      end
    end
  end

  // Register: valid always advances, data loads only with valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      loc_o <= '0;
      acc_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        loc_o <= loc_n;
        acc_o <= acc_n;
      end
    end
  end
endmodule

// File: rtl/rns_mx_converter.sv
module rns_mx_converter
  import rns_mx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NCH*LW-1:0] in_res,
  output logic              out_valid,
  output logic [VW-1:0]     out_value
);
  logic srst_n;
  logic v_s   [NCH+1];
  loc_t loc_s [NCH+1];
  val_t acc_s [NCH+1];

  rns_mx_rst_sync u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rns_mx_canon u_canon (
    .raw (in_res),
    .loc (loc_s[0])
  );

  assign v_s[0]   = in_valid;
  assign acc_s[0] = '0;

  for (genvar k = 0; k < NCH; k++) begin : g_stage
    rns_mx_stage #(.K(k)) u_stage (
      .clk   (clk),
      .rst_n (srst_n),
      .v_i   (v_s[k]),
      .loc_i (loc_s[k]),
      .acc_i (acc_s[k]),
      .v_o   (v_s[k+1]),
      .loc_o (loc_s[k+1]),
      .acc_o (acc_s[k+1])
    );
  end

  assign out_valid = v_s[NCH];
  assign out_value = acc_s[NCH];
endmodule

// File: rtl/rns_mx_chk.sv
module rns_mx_chk
  import rns_mx_pkg::*;
(
  input logic              clk,
  input logic              srst_n,
  input logic              in_valid,
  input logic [NCH*LW-1:0] in_res,
  input logic              out_valid,
  input logic [VW-1:0]     out_value
);
  logic [3:0] cnt_q;
  logic       armed;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else if (cnt_q < 4'(NCH)) cnt_q <= cnt_q + 4'd1;
  end
  assign armed = (cnt_q >= 4'(NCH));

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!srst_n)
    armed |-> (out_valid == $past(in_valid, NCH))); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    !out_valid |-> $stable(out_value)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> (32'(out_value) < RANGE)); // R6

  for (genvar j = 0; j < NCH; j++) begin : g_res
    AST_RESIDUE_MATCH: assert property (@(posedge clk) disable iff (!srst_n)
      (armed && out_valid) |->
        ((32'(out_value) % MOD[j]) == (32'($past(in_res[j*LW +: LW], NCH)) % MOD[j]))); // R1
  end
endmodule

bind rns_mx_converter rns_mx_chk u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .in_valid  (in_valid),
  .in_res    (in_res),
  .out_valid (out_valid),
  .out_value (out_value)
);

// File: tb/sim_rns_mx_converter.sv
module sim_rns_mx_converter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [19:0] in_res;
  logic        out_valid;
  logic [11:0] out_value;

  always #4 clk = ~clk;

  rns_mx_converter u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_res    (in_res),
    .out_valid (out_valid),
    .out_value (out_value)
  );

  int    M [5] = '{11, 7, 5, 3, 2};
  int    lut [int];
  int    cyc = 0;
  int    nchk = 0;
  int    nfail = 0;
  bit    mon_on = 0;
  bit    done = 0;
  int    exp_q [$];
  int    due_q [$];
  string tag_q [$];
  int    last_val = 0;

  always @(posedge clk) cyc++;

  function automatic int key5(input int a, input int b, input int c, input int d, input int e);
    return (((a * 16 + b) * 16 + c) * 16 + d) * 16 + e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // Driver: one tuple per call, expected value from the reference table
  task automatic send(input int r0, input int r1, input int r2, input int r3, input int r4, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_res   = {4'(r4), 4'(r3), 4'(r2), 4'(r1), 4'(r0)};
    exp_q.push_back(lut[key5(r0 % M[0], r1 % M[1], r2 % M[2], r3 % M[3], r4 % M[4])]);
    due_q.push_back(cyc + 5);
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on) begin
        if (out_valid) begin
          chk(out_value < 12'd2310, "R6", "result bound", int'(out_value), 2309);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5", "result with no matching input", int'(out_value), -1);
          end else begin
            int    e;
            int    d;
            string t;
            e = exp_q.pop_front();
            d = due_q.pop_front();
            t = tag_q.pop_front();
            chk(int'(out_value) == e, t, "converted value", int'(out_value), e);
            chk(cyc == d, "R3", "result cycle", cyc, d);
          end
          last_val = int'(out_value);
        end else begin
          chk(int'(out_value) == last_val, "R4", "idle hold", int'(out_value), last_val);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 200000);
    chk(1'b0, "R3", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    for (int x = 0; x < 2310; x++)
      lut[key5(x % 11, x % 7, x % 5, x % 3, x % 2)] = x;

    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_res   = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R5", "valid in reset", int'(out_valid), 0);
    chk(out_value == 12'd0, "R5", "value in reset", int'(out_value), 0);

    // Tuples in the two-edge release window must be dropped (R5)
    @(negedge clk);
    rst_n    = 1'b1;
    in_valid = 1'b1;
    in_res   = {4'd1, 4'd2, 4'd3, 4'd4, 4'd5};
    mon_on   = 1'b1;
    @(negedge clk);
    in_res   = {4'd0, 4'd1, 4'd1, 4'd6, 4'd10};
    idle(8);
    chk(exp_q.size() == 0, "R5", "queue after release window", exp_q.size(), 0);

    // R1: full sweep with back-to-back input and occasional gaps (R3)
    for (int a = 0; a < 11; a++)
      for (int b = 0; b < 7; b++)
        for (int c = 0; c < 5; c++)
          for (int d = 0; d < 3; d++)
            for (int e = 0; e < 2; e++) begin
              send(a, b, c, d, e, "R1");
              if (((a * 7 + b) * 5 + c) % 13 == 4 && d == 0 && e == 0) idle(1 + (a % 3));
            end
    idle(7);

    // R1 corners: zero, top of range, single-lane tuples
    send(0, 0, 0, 0, 0, "R1");
    send(10, 6, 4, 2, 1, "R1");
    send(1, 1, 1, 1, 1, "R1");
    send(0, 0, 0, 0, 1, "R1");
    idle(3);

    // R2: lanes at or above their modulus
    send(15, 15, 15, 15, 15, "R2");
    send(11, 7, 5, 3, 2, "R2");
    send(12, 9, 7, 4, 3, "R2");
    for (int i = 0; i < 40; i++)
      send($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 15), $urandom_range(0, 15), "R2");
    idle(12);

    chk(exp_q.size() == 0, "R3", "results outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule